// File: doc/BRIEF.md
# Pattern-Table Bank Mapper with Fetch-Steered 4K Windows

This block sits between the picture processor's pattern-table address bus (8 KiB, 13 address bits) and a large character ROM. It holds eight 16-bit bank numbers and composes a ROM address from the fetch address, a window-size setting and a small outer-bank field. The processor loads each bank number one byte at a time: a low-byte page and a high-byte page are each decoded from the write address.

The 8 KiB space can be cut into one 8K window, two 4K windows, four 2K windows or eight 1K windows. In 4K mode each half has two candidate bank registers. A per-half selector picks one of them, and pattern fetches of particular tiles flip that selector. Outside full-range mode, the 3-bit outer bank is placed above the masked bank number. The mask width and the outer shift grow with the window count. The window size, outer bank and full-range flag come from a neighbouring control register as plain inputs. The address output is combinational from the fetch address and the held state.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset every bank register holds 0xFFFF, and both 4K selectors choose their first register (register 0 for the low half, register 4 for the high half).
- R2: A write with wr_addr[15:12]=0x9 loads bits [7:0] of register wr_addr[2:0], and a write with wr_addr[15:12]=0xA loads bits [15:8] of that register. Writes to any other page change no register. A write takes effect on the clock edge.
- R3: When size_mode=0 (one 8K window), register 0 supplies the bank, and chr_addr = bank*8192 + ppu_addr[12:0].
- R4: When size_mode=1 (two 4K windows), ppu_addr[12]=0 uses register 0 or 2 and ppu_addr[12]=1 uses register 4 or 6, as the selector for that half dictates. chr_addr = bank*4096 + ppu_addr[11:0].
- R5: When size_mode=2 (four 2K windows), register 2*ppu_addr[12:11] supplies the bank, and chr_addr = bank*2048 + ppu_addr[10:0].
- R6: When size_mode=3 (eight 1K windows), register ppu_addr[12:10] supplies the bank, and chr_addr = bank*1024 + ppu_addr[9:0].
- R7: When full_range=0, the bank is (register AND mask) OR (outer_bank << shift). For size_mode 0, 1, 2 and 3 the mask is 0x1F, 0x3F, 0x7F and 0xFF, and the shift is 5, 6, 7 and 8.
- R8: When full_range=1, the bank is the full 16-bit register value, and outer_bank has no effect.
- R9: A cycle with ppu_rd=1 and ppu_addr[11:8]=0xF updates the selector of half ppu_addr[12] at the clock edge. If ppu_addr[7:4]=0xD the selector takes the first register; if ppu_addr[7:4]=0xE it takes the second. The selectors update in every mode.
- R10: A fetch whose ppu_addr[11:4] is neither 0xFD nor 0xFE leaves the selectors unchanged. A cycle with ppu_rd=0 also leaves them unchanged, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor register write strobe |
| wr_addr | input | 16 | Processor write address (page and register index) |
| wr_data | input | 8 | Processor write data byte |
| size_mode | input | 2 | Window size: 0=8K, 1=4K, 2=2K, 3=1K |
| outer_bank | input | 3 | Outer bank field |
| full_range | input | 1 | 1 = unmasked 16-bit bank numbers |
| ppu_rd | input | 1 | Pattern fetch strobe |
| ppu_addr | input | 13 | Pattern-table fetch address |
| chr_addr | output | 29 | Composed character ROM address |

## Verification
The bench steers the 4K selectors with fetches of tiles 0xFD and 0xFE in both halves. It also issues near-miss tiles such as 0xFF and 0xEF, and 0xFD addresses with the strobe low. A design with a loose tile compare, or one that ignores the strobe, shows the wrong 4K register. Writes to neighbouring pages 0x8 and 0xB must leave the bank numbers intact, which exposes a sloppy page decode. Random sweeps set the outer bank together with all-ones bank registers in every mode, so an off-by-one mask or shift corrupts the upper bits. The same sweeps toggle full_range, so a design that keeps applying the outer bank in full-range mode is caught.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

    parameter int BANK_W      = 16;
    parameter int NUM_BANKS   = 8;
    parameter int PAT_AW      = 13;
    parameter int OUTER_W     = 3;
    parameter int BASE_SHIFT  = 5;
    parameter int CHR_AW      = BANK_W + PAT_AW;
    parameter int IDX_W       = $clog2(NUM_BANKS);

    parameter logic [3:0] LO_PAGE   = 4'h9;
    parameter logic [3:0] HI_PAGE   = 4'hA;
    parameter logic [3:0] TRIG_ROW  = 4'hF;
    parameter logic [3:0] TILE_PRI  = 4'hD;
    parameter logic [3:0] TILE_ALT  = 4'hE;

    typedef enum logic [1:0] {
        SZ_8K = 2'd0,
        SZ_4K = 2'd1,
        SZ_2K = 2'd2,
        SZ_1K = 2'd3
    } chr_size_e;

    typedef struct packed {
        logic hit;
        logic half;
        logic alt;
    } fetch_evt_t;

    function automatic int win_shift(input chr_size_e m);
        return BASE_SHIFT + int'(m);
    endfunction

    function automatic logic [BANK_W-1:0] inner_mask(input chr_size_e m);
        return (BANK_W'(1) << win_shift(m)) - BANK_W'(1);
    endfunction

    function automatic int offset_bits(input chr_size_e m);
        return PAT_AW - int'(m);
    endfunction

endpackage

// File: rtl/chr_regfile.sv
module chr_regfile
    import chr_map_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [15:0]           wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NB-1:0][BW-1:0] bank_q
);
    localparam int IW = $clog2(NB);

    logic lo_page, hi_page;
    assign lo_page = wr_en && (wr_addr[15:12] == LO_PAGE);
    assign hi_page = wr_en && (wr_addr[15:12] == HI_PAGE);

    for (genvar g = 0; g < NB; g++) begin : g_reg
        logic hit;
        assign hit = (wr_addr[IW-1:0] == IW'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '1;
            end else begin
                if (lo_page && hit) bank_q[g][7:0]    <= wr_data;
                if (hi_page && hit) bank_q[g][BW-1:8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
    import chr_map_pkg::*;
#(
    parameter int AW = PAT_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ppu_rd,
    input  logic [AW-1:0] ppu_addr,
    output logic [1:0]    sel_alt
);
    fetch_evt_t evt;

    always_comb begin
        evt.half = ppu_addr[AW-1];
        evt.alt  = (ppu_addr[7:4] == TILE_ALT);
        evt.hit  = ppu_rd && (ppu_addr[11:8] == TRIG_ROW) &&
                   ((ppu_addr[7:4] == TILE_PRI) || (ppu_addr[7:4] == TILE_ALT));
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst)
                sel_alt[h] <= 1'b0;
            else if (evt.hit && (evt.half == 1'(h)))
                sel_alt[h] <= evt.alt;
        end
    end
endmodule

// File: rtl/chr_compose.sv
module chr_compose
    import chr_map_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = PAT_AW,
    parameter int OW = OUTER_W,
    parameter int CW = CHR_AW
) (
    input  logic [NB-1:0][BW-1:0] bank_q,
    input  logic [1:0]            sel_alt,
    input  chr_size_e             mode,
    input  logic [OW-1:0]         outer,
    input  logic                  full,
    input  logic [AW-1:0]         ppu_addr,
    output logic [CW-1:0]         chr_addr
);
    localparam int IW = $clog2(NB);

    logic [IW-1:0] idx;
    logic [BW-1:0] raw, bank;
    logic [CW-1:0] off_mask;
    int            obits;

    always_comb begin
        unique case (mode)
            SZ_8K: idx = '0;
            SZ_4K: idx = ppu_addr[AW-1] ? (sel_alt[1] ? IW'(6) : IW'(4))
                                        : (sel_alt[0] ? IW'(2) : IW'(0));
            SZ_2K: idx = {ppu_addr[AW-1:AW-2], 1'b0};
            default: idx = ppu_addr[AW-1:AW-3];
        endcase
        raw = bank_q[idx];
        if (full)
            bank = raw;
        else
            bank = (raw & inner_mask(mode)) | (BW'(outer) << win_shift(mode));
        obits    = offset_bits(mode);
        off_mask = (CW'(1) << obits) - CW'(1);
        chr_addr = (CW'(bank) << obits) | (CW'(ppu_addr) & off_mask);
    end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import chr_map_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [15:0]         wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [1:0]          size_mode,
    input  logic [OUTER_W-1:0]  outer_bank,
    input  logic                full_range,
    input  logic                ppu_rd,
    input  logic [PAT_AW-1:0]   ppu_addr,
    output logic [CHR_AW-1:0]   chr_addr
);
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
    logic [1:0]                       sel_alt;

    chr_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bank_q (bank_q)
    );

    chr_fetch_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ppu_rd  (ppu_rd),
        .ppu_addr(ppu_addr),
        .sel_alt (sel_alt)
    );

    chr_compose u_comp (
        .bank_q  (bank_q),
        .sel_alt (sel_alt),
        .mode    (chr_size_e'(size_mode)),
        .outer   (outer_bank),
        .full    (full_range),
        .ppu_addr(ppu_addr),
        .chr_addr(chr_addr)
    );
endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk
    import chr_map_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             wr_en,
    input logic [15:0]                      wr_addr,
    input logic [7:0]                       wr_data,
    input logic [1:0]                       size_mode,
    input logic                             full_range,
    input logic                             ppu_rd,
    input logic [PAT_AW-1:0]                ppu_addr,
    input logic [CHR_AW-1:0]                chr_addr,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q,
    input logic [1:0]                       sel_alt
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (bank_q[0] == '1) && (bank_q[NUM_BANKS-1] == '1) && (sel_alt == 2'b00));

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:12] == LO_PAGE)
        |=> bank_q[$past(wr_addr[IDX_W-1:0])][7:0] == $past(wr_data));

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[15:12] == HI_PAGE)
        |=> bank_q[$past(wr_addr[IDX_W-1:0])][BANK_W-1:8] == $past(wr_data));

    // R2
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr[15:12] == LO_PAGE || wr_addr[15:12] == HI_PAGE))
        |=> $stable(bank_q));

    // R9
    sel_pri_chk: assert property (@(posedge clk) disable iff (rst)
        (ppu_rd && ppu_addr[11:4] == 8'hFD) |=> sel_alt[$past(ppu_addr[PAT_AW-1])] == 1'b0);

    // R9
    sel_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (ppu_rd && ppu_addr[11:4] == 8'hFE) |=> sel_alt[$past(ppu_addr[PAT_AW-1])] == 1'b1);

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ppu_rd || (ppu_addr[11:4] != 8'hFD && ppu_addr[11:4] != 8'hFE)) |=> $stable(sel_alt));

    // R8
    full_1k_chk: assert property (@(posedge clk) disable iff (rst)
        (full_range && size_mode == 2'd3)
        |-> chr_addr[CHR_AW-1:10] == (CHR_AW-10)'(bank_q[ppu_addr[PAT_AW-1:PAT_AW-3]]));
endmodule

bind chr_bank_mapper chr_bank_mapper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .size_mode (size_mode),
    .full_range(full_range),
    .ppu_rd    (ppu_rd),
    .ppu_addr  (ppu_addr),
    .chr_addr  (chr_addr),
    .bank_q    (bank_q),
    .sel_alt   (sel_alt)
);

// File: tb/sim_chr_bank_mapper.sv
module sim_chr_bank_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  size_mode = '0;
    logic [2:0]  outer_bank = '0;
    logic        full_range = 1'b0;
    logic        ppu_rd = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [28:0] chr_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_lo [8];
    logic [7:0] m_hi [8];
    logic       m_sel [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    chr_bank_mapper u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .size_mode(size_mode), .outer_bank(outer_bank), .full_range(full_range),
        .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
    );

    function automatic logic [28:0] model_addr(input logic [1:0] m, input logic [2:0] o,
                                               input logic f, input logic [12:0] pa);
        int idx;
        logic [15:0] raw, bank;
        case (m)
            2'd0: idx = 0;
            2'd1: idx = pa[12] ? (m_sel[1] ? 6 : 4) : (m_sel[0] ? 2 : 0);
            2'd2: idx = 2 * int'(pa[12:11]);
            default: idx = int'(pa[12:10]);
        endcase
        raw = {m_hi[idx], m_lo[idx]};
        if (f) bank = raw;
        else case (m)
            2'd0: bank = (raw & 16'h001F) | (16'(o) << 5);
            2'd1: bank = (raw & 16'h003F) | (16'(o) << 6);
            2'd2: bank = (raw & 16'h007F) | (16'(o) << 7);
            default: bank = (raw & 16'h00FF) | (16'(o) << 8);
        endcase
        case (m)
            2'd0: return {bank, pa};
            2'd1: return {1'b0, bank, pa[11:0]};
            2'd2: return {2'b0, bank, pa[10:0]};
            default: return {3'b0, bank, pa[9:0]};
        endcase
    endfunction

    task automatic check(input string req, input logic [28:0] got, input logic [28:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: chr_addr=%h expected=%h", req, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check the combinational output, then let the model take the edge.
    task automatic step(input logic we, input logic [15:0] wa, input logic [7:0] wd,
                        input logic [1:0] m, input logic [2:0] o, input logic f,
                        input logic rd, input logic [12:0] pa, input string req);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        size_mode = m; outer_bank = o; full_range = f;
        ppu_rd = rd; ppu_addr = pa;
        #1;
        check(req, chr_addr, model_addr(m, o, f, pa));
        if (we && wa[15:12] == 4'h9) m_lo[wa[2:0]] = wd;
        if (we && wa[15:12] == 4'hA) m_hi[wa[2:0]] = wd;
        if (rd && pa[11:8] == 4'hF && (pa[7:4] == 4'hD || pa[7:4] == 4'hE))
            m_sel[pa[12]] = (pa[7:4] == 4'hE);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 8; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
        m_sel[0] = 1'b0; m_sel[1] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, literal expectations
        @(negedge clk);
        size_mode = 2'd3; outer_bank = 3'd0; full_range = 1'b0; ppu_addr = 13'h0400; #1;
        check("R1 1K reset bank", chr_addr, 29'h3FC00);
        size_mode = 2'd1; ppu_addr = 13'h1000; #1;
        check("R1 4K high half reg4", chr_addr, 29'h3F000);
        full_range = 1'b1; size_mode = 2'd0; ppu_addr = 13'h0000; #1;
        check("R1 full 8K", chr_addr, 29'h1FFFE000);

        // R2: split writes, then writes to other pages ignored
        step(1, 16'h9003, 8'h12, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 lo write");
        step(1, 16'hA00B, 8'h34, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 hi write");
        step(0, 16'h0000, 8'h00, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 read back");
        check("R2 literal", chr_addr, 29'h0D04805);
        step(1, 16'hB003, 8'h00, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 page B");
        step(1, 16'h8003, 8'h00, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 page 8");
        step(0, 16'h0000, 8'h00, 2'd3, 3'd0, 1, 0, 13'h0C05, "R2 ignored writes");
        check("R2 ignored literal", chr_addr, 29'h0D04805);

        // R7 / R8: outer bank in 1K mode, and full range ignoring it
        step(0, 16'h0, 8'h0, 2'd3, 3'd5, 0, 0, 13'h0C05, "R7 outer 1K");
        check("R7 literal", chr_addr, 29'h0144805);
        step(0, 16'h0, 8'h0, 2'd3, 3'd7, 1, 0, 13'h0C05, "R8 outer ignored");
        check("R8 literal", chr_addr, 29'h0D04805);
        step(0, 16'h0, 8'h0, 2'd0, 3'd7, 0, 0, 13'h1ABC, "R3 8K outer");
        step(0, 16'h0, 8'h0, 2'd2, 3'd2, 0, 0, 13'h0FFF, "R5 2K outer");

        // R9 / R10: 4K selectors
        step(1, 16'h9002, 8'h21, 2'd1, 3'd0, 1, 0, 13'h0010, "R4 setup");
        step(1, 16'hA002, 8'h00, 2'd1, 3'd0, 1, 1, 13'h0FE0, "R9 fetch FE low");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 0, 13'h0010, "R9 low uses reg2");
        check("R9 literal", chr_addr, 29'h0021010);
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 0, 13'h0FD0, "R10 no strobe");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 1, 13'h0FF0, "R10 tile FF");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 1, 13'h0EF0, "R10 tile EF");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 0, 13'h0010, "R10 still reg2");
        check("R10 literal", chr_addr, 29'h0021010);
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 1, 13'h1FE8, "R9 fetch FE high");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 1, 13'h0FD4, "R9 fetch FD low");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 0, 13'h0010, "R9 low back reg0");
        step(0, 16'h0, 8'h0, 2'd1, 3'd0, 1, 0, 13'h1010, "R9 high reg6");

        // Random sweep over all modes, pages, outer fields and fetches
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] wa;
            logic [12:0] pa;
            logic [1:0]  m;
            logic        f;
            string       tag;
            case ($urandom_range(0, 4))
                0: wa = {4'h9, 12'($urandom)};
                1: wa = {4'hA, 12'($urandom)};
                2: wa = {4'hB, 12'($urandom)};
                3: wa = {4'h8, 12'($urandom)};
                default: wa = 16'($urandom);
            endcase
            if ($urandom_range(0, 2) == 0)
                pa = {1'($urandom), 4'hF, ($urandom_range(0, 1) != 0) ? 4'hD : 4'hE, 4'($urandom)};
            else
                pa = 13'($urandom);
            m = 2'($urandom);
            f = ($urandom_range(0, 3) == 0);
            case (m)
                2'd0: tag = f ? "R3/R8 8K" : "R3/R7 8K";
                2'd1: tag = f ? "R4/R8 4K" : "R4/R7 4K";
                2'd2: tag = f ? "R5/R8 2K" : "R5/R7 2K";
                default: tag = f ? "R6/R8 1K" : "R6/R7 1K";
            endcase
            step(1'($urandom), wa, 8'($urandom), m, 3'($urandom), f, 1'($urandom), pa, tag);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule